// File: doc/BRIEF.md
# Sampling Runahead Throttle

This block decides whether a core may start a runahead episode. It works in sampling windows. Each window is a fixed number of consecutive runahead episodes, and the block adds up the long-latency misses those episodes produce. When the last episode of a window ends, the block compares that total with a floor.

- If the total reaches the floor, runahead stays allowed and a new window begins.
- If the total falls short, the block withdraws entry permission. Permission comes back only after a set number of long-latency misses have occurred in normal mode. A new window then starts from zero.

A second, independent monitor runs inside each episode. It counts the loads that execute and the loads among them whose result is invalid because they depend on a miss. Once enough loads have been seen, it compares the invalid share with a fixed ratio. It uses two multiplications for this, so no divider is needed. If the invalid share is above the ratio, the monitor raises a one-cycle request to leave runahead early. It raises this request at most once per episode.

The core uses these outputs as follows. It gates its runahead entry decision with `entry_en`, and it treats `force_exit` like a completed miss that ends the episode.

Top module: `ra_sample_gate`

## Requirements
- R1: During and right after reset, `entry_en` is 1 and `force_exit` is 0.
- R2: Suppose that, when the WIN_EPIS-th `epi_end` pulse of a window occurs, the window's `ra_miss` total is below MISS_FLOOR. A miss in that same cycle counts toward the total. Then `entry_en` reads 0 from the next cycle on (transition SAMPLE to LOCKOUT).
- R3: If the window total at that point is equal to or above MISS_FLOOR, `entry_en` stays 1 and a new window starts.
- R4: In LOCKOUT, each `nm_miss` pulse uses up one of LOCK_MISSES. The LOCK_MISSES-th pulse makes `entry_en` read 1 in the next cycle (transition LOCKOUT to SAMPLE). `nm_miss` has no effect in SAMPLE.
- R5: Episodes and `ra_miss` pulses that occur during LOCKOUT do not count toward any window.
- R6: After the return to SAMPLE, the window starts with zero episodes and zero misses.
- R7: A load is counted only if `ld_exec` is 1. `ld_inv` marks that same load as invalid. Inside an episode, `force_exit` rises in the cycle after the load that makes invalid×INV_DEN strictly greater than loads×INV_NUM (transition WATCH to FIRED).
- R8: `force_exit` stays 0 until at least MIN_LOADS loads have been counted in the current episode.
- R9: `force_exit` lasts one cycle and is raised at most once per episode.
- R10: `epi_start` clears both load counts of the monitor and begins a new episode (transition to WATCH from any state).
- R11: Loads outside an episode are ignored. `epi_end` returns the monitor to IDLE, where `force_exit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| epi_start | input | 1 | Pulse: a runahead episode begins |
| epi_end | input | 1 | Pulse: the runahead episode ends |
| ra_miss | input | 1 | Pulse: a new long-latency miss is generated in runahead |
| ld_exec | input | 1 | Pulse: a load is executed in runahead |
| ld_inv | input | 1 | Qualifies `ld_exec`: that load is invalid |
| nm_miss | input | 1 | Pulse: a long-latency miss occurs in normal mode |
| entry_en | output | 1 | Runahead entry allowed |
| force_exit | output | 1 | One-cycle request to leave runahead early |

## Verification
The bench builds the block with the following parameters:

- WIN_EPIS = 4, LOCK_MISSES = 5 and MISS_FLOOR = 3. With these values a whole window, a lockout and the re-enable can be covered in a few dozen cycles. The bench also hits a total exactly at the floor and a lockout that ends on its last miss.
- INV_NUM = 1 and INV_DEN = 2, with MIN_LOADS left at 8. With these values the ratio test can be driven to the equal case, which must not fire, and to the first case that is strictly above, which must fire. A run of invalid loads just short of the minimum count shows that the minimum holds the request back.

// File: rtl/ra_gate_pkg.sv
package ra_gate_pkg;

    // Sampling-window controller states
    typedef enum logic {
        ST_SAMPLE  = 1'b0,
        ST_LOCKOUT = 1'b1
    } win_state_t;

    // In-episode invalid-load monitor states
    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_WATCH = 2'd1,
        MON_FIRED = 2'd2
    } mon_state_t;

endpackage

// File: rtl/ra_window_sampler.sv
module ra_window_sampler
    import ra_gate_pkg::*;
#(
    parameter int WIN_EPIS    = 100,
    parameter int LOCK_MISSES = 1000,
    parameter int MISS_FLOOR  = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic epi_end,
    input  logic ra_miss,
    input  logic nm_miss,
    output logic entry_en
);

    localparam int EP_W = $clog2(WIN_EPIS + 1);
    localparam int MS_W = $clog2(MISS_FLOOR + 2);
    localparam int LK_W = $clog2(LOCK_MISSES + 1);
    localparam logic [EP_W-1:0] LAST_EP = EP_W'(WIN_EPIS - 1);
    localparam logic [MS_W-1:0] MS_CAP  = MS_W'(MISS_FLOOR);
    localparam logic [LK_W-1:0] LK_INIT = LK_W'(LOCK_MISSES);

    win_state_t      state_q, state_d;
    logic [EP_W-1:0] ep_q, ep_d;
    logic [MS_W-1:0] ms_q, ms_d, ms_sum;
    logic [LK_W-1:0] lk_q, lk_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
            ep_q    <= '0;
            ms_q    <= '0;
            lk_q    <= '0;
        end else begin
            state_q <= state_d;
            ep_q    <= ep_d;
            ms_q    <= ms_d;
            lk_q    <= lk_d;
        end
    end

    // Miss total saturates at the floor; beyond that the comparison is settled
    always_comb begin
        ms_sum = (ra_miss && (ms_q < MS_CAP)) ? ms_q + 1'b1 : ms_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ep_d    = ep_q;
        ms_d    = ms_q;
        lk_d    = lk_q;
        unique case (state_q)
            ST_SAMPLE: begin
                ms_d = ms_sum;
                if (epi_end) begin
                    if (ep_q == LAST_EP) begin
                        ep_d = '0;
                        ms_d = '0;
                        if (ms_sum < MS_CAP) begin
                            state_d = ST_LOCKOUT;
                            lk_d    = LK_INIT;
                        end
                    end else begin
                        ep_d = ep_q + 1'b1;
                    end
                end
            end
            ST_LOCKOUT: begin
                if (nm_miss) begin
                    if (lk_q <= LK_W'(1)) begin
                        state_d = ST_SAMPLE;
                        lk_d    = '0;
                    end else begin
                        lk_d = lk_q - 1'b1;
                    end
                end
            end
        endcase
    end

    // Output logic
    always_comb begin
        entry_en = (state_q == ST_SAMPLE);
    end

endmodule

// File: rtl/ra_inv_monitor.sv
module ra_inv_monitor
    import ra_gate_pkg::*;
#(
    parameter int MIN_LOADS = 8,
    parameter int LD_MAX    = 255,
    parameter int INV_NUM   = 1,
    parameter int INV_DEN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic epi_start,
    input  logic epi_end,
    input  logic ld_exec,
    input  logic ld_inv,
    output logic force_exit
);

    localparam int LD_W = $clog2(LD_MAX + 1);
    localparam int PW   = LD_W + 16;
    localparam logic [LD_W-1:0] LD_TOP  = LD_W'(LD_MAX);
    localparam logic [LD_W-1:0] LD_MIN  = LD_W'(MIN_LOADS);
    localparam logic [PW-1:0]   NUM_EXT = PW'(INV_NUM);
    localparam logic [PW-1:0]   DEN_EXT = PW'(INV_DEN);

    mon_state_t      state_q, state_d;
    logic [LD_W-1:0] ld_q, ld_d, inv_q, inv_d;
    logic [PW-1:0]   inv_scaled, ld_scaled;
    logic            ratio_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_IDLE;
            ld_q    <= '0;
            inv_q   <= '0;
        end else begin
            state_q <= state_d;
            ld_q    <= ld_d;
            inv_q   <= inv_d;
        end
    end

    // Division-free ratio test on the registered counts
    always_comb begin
        inv_scaled = PW'(inv_q) * DEN_EXT;
        ld_scaled  = PW'(ld_q) * NUM_EXT;
        ratio_hit  = (ld_q >= LD_MIN) && (inv_scaled > ld_scaled);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ld_d    = ld_q;
        inv_d   = inv_q;
        if (epi_start) begin
            state_d = MON_WATCH;
            ld_d    = '0;
            inv_d   = '0;
        end else begin
            unique case (state_q)
                MON_IDLE: begin
                    state_d = MON_IDLE;
                end
                MON_WATCH: begin
                    if (epi_end) begin
                        state_d = MON_IDLE;
                    end else if (ratio_hit) begin
                        state_d = MON_FIRED;
                    end
                    if (ld_exec && (ld_q < LD_TOP)) begin
                        ld_d = ld_q + 1'b1;
                        if (ld_inv) begin
                            inv_d = inv_q + 1'b1;
                        end
                    end
                end
                MON_FIRED: begin
                    if (epi_end) begin
                        state_d = MON_IDLE;
                    end
                end
                default: begin
                    state_d = MON_IDLE;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        force_exit = (state_q == MON_WATCH) && ratio_hit;
    end

endmodule

// File: rtl/ra_sample_gate.sv
module ra_sample_gate #(
    parameter int WIN_EPIS    = 100,
    parameter int LOCK_MISSES = 1000,
    parameter int MISS_FLOOR  = 25,
    parameter int MIN_LOADS   = 8,
    parameter int LD_MAX      = 255,
    parameter int INV_NUM     = 1,
    parameter int INV_DEN     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic epi_start,
    input  logic epi_end,
    input  logic ra_miss,
    input  logic ld_exec,
    input  logic ld_inv,
    input  logic nm_miss,
    output logic entry_en,
    output logic force_exit
);

    ra_window_sampler #(
        .WIN_EPIS    (WIN_EPIS),
        .LOCK_MISSES (LOCK_MISSES),
        .MISS_FLOOR  (MISS_FLOOR)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .epi_end  (epi_end),
        .ra_miss  (ra_miss),
        .nm_miss  (nm_miss),
        .entry_en (entry_en)
    );

    ra_inv_monitor #(
        .MIN_LOADS (MIN_LOADS),
        .LD_MAX    (LD_MAX),
        .INV_NUM   (INV_NUM),
        .INV_DEN   (INV_DEN)
    ) u_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .epi_start  (epi_start),
        .epi_end    (epi_end),
        .ld_exec    (ld_exec),
        .ld_inv     (ld_inv),
        .force_exit (force_exit)
    );

endmodule

// File: rtl/ra_sample_gate_chk.sv
module ra_sample_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic epi_end,
    input logic ld_exec,
    input logic nm_miss,
    input logic entry_en,
    input logic force_exit
);

    // R9
    exit_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_exit |=> !force_exit);

    // R7
    exit_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_exit) |-> $past(ld_exec));

    // R4
    reenable_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_en) |-> $past(nm_miss));

    // R2
    disable_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(entry_en) |-> $past(epi_end));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (entry_en && !force_exit);
        end
    end

endmodule

bind ra_sample_gate ra_sample_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .epi_end    (epi_end),
    .ld_exec    (ld_exec),
    .nm_miss    (nm_miss),
    .entry_en   (entry_en),
    .force_exit (force_exit)
);

// File: tb/ra_sample_gate_bench.sv
module ra_sample_gate_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic epi_start = 1'b0, epi_end = 1'b0, ra_miss = 1'b0;
    logic ld_exec = 1'b0, ld_inv = 1'b0, nm_miss = 1'b0;
    logic entry_en, force_exit;

    always #4 clk = ~clk;

    ra_sample_gate #(
        .WIN_EPIS    (4),
        .LOCK_MISSES (5),
        .MISS_FLOOR  (3),
        .MIN_LOADS   (8),
        .LD_MAX      (255),
        .INV_NUM     (1),
        .INV_DEN     (2)
    ) u_ra_sample_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .epi_start  (epi_start),
        .epi_end    (epi_end),
        .ra_miss    (ra_miss),
        .ld_exec    (ld_exec),
        .ld_inv     (ld_inv),
        .nm_miss    (nm_miss),
        .entry_en   (entry_en),
        .force_exit (force_exit)
    );

    typedef struct {
        string req;
        logic  en;
        logic  fx;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Monitor: pops expected items and compares with outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                n_cmp++;
                if (entry_en !== it.en || force_exit !== it.fx) begin
                    n_bad++;
                    $display("FAIL %s: entry_en/force_exit = %b/%b, expected %b/%b",
                             it.req, entry_en, force_exit, it.en, it.fx);
                end
            end
        end
    end

    task automatic expect_out(input string r, input logic en, input logic fx);
        exp_t it;
        it.req = r;
        it.en  = en;
        it.fx  = fx;
        exp_q.push_back(it);
    endtask

    task automatic pulse(input logic s, input logic e, input logic rm,
                         input logic le, input logic li, input logic nm);
        @(negedge clk);
        epi_start = s; epi_end = e; ra_miss = rm;
        ld_exec = le; ld_inv = li; nm_miss = nm;
        @(negedge clk);
        epi_start = 1'b0; epi_end = 1'b0; ra_miss = 1'b0;
        ld_exec = 1'b0; ld_inv = 1'b0; nm_miss = 1'b0;
    endtask

    task automatic episode(input int misses);
        pulse(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < misses; i++) pulse(0, 0, 1, 0, 0, 0);
        pulse(0, 1, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1'b1, 1'b0);

        // nm_miss while sampling has no effect
        pulse(0, 0, 0, 0, 0, 1);
        expect_out("R4 nm_miss ignored in SAMPLE", 1'b1, 1'b0);

        // Window total exactly at floor
        episode(1); episode(1); episode(0); episode(1);
        expect_out("R3 total equals floor", 1'b1, 1'b0);

        // Window below floor
        episode(1); episode(0); episode(1);
        expect_out("R2 window not yet closed", 1'b1, 1'b0);
        episode(0);
        expect_out("R2 total below floor", 1'b0, 1'b0);

        // Activity while locked out is not counted
        episode(5);
        expect_out("R5 episode during lockout", 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) pulse(0, 0, 0, 0, 0, 1);
        expect_out("R4 four of five misses", 1'b0, 1'b0);
        pulse(0, 0, 0, 0, 0, 1);
        expect_out("R4 lockout expired", 1'b1, 1'b0);

        // Fresh window: three empty episodes keep it open
        episode(0); episode(0); episode(0);
        expect_out("R6 fresh window after three", 1'b1, 1'b0);
        episode(0);
        expect_out("R6 fresh window closes low", 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) pulse(0, 0, 0, 0, 0, 1);
        expect_out("R4 re-enable again", 1'b1, 1'b0);

        // Monitor: minimum load count
        pulse(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) pulse(0, 0, 0, 1, 1, 0);
        expect_out("R8 seven invalid loads", 1'b1, 1'b0);
        pulse(0, 0, 0, 1, 1, 0);
        expect_out("R7 eighth invalid load fires", 1'b1, 1'b1);
        pulse(0, 0, 0, 0, 0, 0);
        expect_out("R9 pulse lasts one cycle", 1'b1, 1'b0);
        pulse(0, 0, 0, 1, 1, 0);
        pulse(0, 0, 0, 1, 1, 0);
        expect_out("R9 once per episode", 1'b1, 1'b0);
        pulse(0, 1, 0, 0, 0, 0);

        // Monitor: equal ratio does not fire, strictly above fires
        pulse(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            pulse(0, 0, 0, 1, 0, 0);
            pulse(0, 0, 0, 1, 1, 0);
        end
        expect_out("R7 ratio equal no exit", 1'b1, 1'b0);
        pulse(0, 0, 0, 1, 1, 0);
        expect_out("R7 ratio above exits", 1'b1, 1'b1);
        pulse(0, 1, 0, 0, 0, 0);
        expect_out("R11 idle after end", 1'b1, 1'b0);

        // Loads outside an episode are ignored
        for (int i = 0; i < 9; i++) pulse(0, 0, 0, 1, 1, 0);
        expect_out("R11 loads outside episode", 1'b1, 1'b0);

        // New episode clears counts
        pulse(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) pulse(0, 0, 0, 1, 1, 0);
        expect_out("R10 counts cleared at start", 1'b1, 1'b0);
        pulse(0, 0, 0, 1, 0, 0);
        expect_out("R10 fires at eighth load", 1'b1, 1'b1);
        pulse(0, 1, 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule